// File: doc/BRIEF.md
# Prefetch Decode and Issue

This block sits beside a load/store pipeline and takes over the 32-bit prefetch instructions. Two encodings are recognised. One carries a 9-bit signed displacement and has a variant that is translated with user privileges while the core runs in kernel mode. The other carries a 12-bit unsigned displacement. For each instruction the block adds the displacement to the supplied base register value and presents the resulting address, together with a user-mode translation flag, to an external translation unit. That unit answers in the same cycle with fault, uncached and locked-line flags.

One cycle after it accepts an instruction, the block reports exactly one outcome: issued, dropped or exception. An issued prefetch becomes a request on a valid/ready channel. The request carries the address, the target cache level, a usage class and a store-intent bit. Reserved hints never trap: they are dropped silently. Any addressing trouble is also dropped silently. The only exceptions raised belong to the user-mode-translated variant, when that feature or the system coprocessor is unavailable.

Top module: `prefetch_issue`

## Requirements
- R1: A word with bits 31:26 = 101001, bits 14:11 = 0011, bit 10 = 0 and bits 9:8 = 00 or 10 is claimed when its hint (bits 25:21) is not 31. Its displacement is the 9-bit value {bit 15, bits 7:0}, sign-extended, and `xlat_addr` shows base plus displacement in the same cycle.
- R2: A word with bits 31:26 = 100001 and bits 15:12 = 0011 is claimed when its hint is not 31. Its displacement is bits 11:0, zero-extended. This form never uses user-mode translation.
- R3: A hint of 31, or any word matching neither form, drives `in_claim` low, is never accepted and produces no outcome.
- R4: For an issued prefetch, `req_level` is hint bits 4:3 (0 = L1, 1 = L2, 2 = L3). The low three bits of the hint give `req_store` and `req_class` (0 plain, 1 streamed, 2 retained, 3 LRU-mark) as follows: 0 load plain; 1 store plain; 2 load LRU-mark; 4 load streamed; 5 store streamed; 6 load retained; 7 store retained.
- R5: Hints 24 to 30, and any hint whose low three bits are 3, end with outcome dropped and no request.
- R6: In the user-mode-translated variant (bits 9:8 = 10), a low `eva_enable` gives an exception with `res_exc` = 1. Otherwise a low `cp0_enable` gives an exception with `res_exc` = 2. The first check wins over the second, and both win over the no-op and drop rules. No request follows an exception.
- R7: When `xlat_fault`, `xlat_uncached` or `xlat_locked` is high at acceptance, the outcome is dropped and no request is made. No exception is raised.
- R8: `xlat_user` is high exactly for a claimed word of the user-mode-translated variant, and `req_user` carries that flag with the request.
- R9: An instruction is accepted when `in_valid`, `in_ready` and `in_claim` are all high. `res_valid` pulses for one cycle in the following cycle, with `res_kind` 1 issued, 2 dropped or 3 exception. In all other cycles `res_valid` is low.
- R10: A request stays valid, with every field unchanged, until `req_ready` is high. `in_ready` is low while a request is pending.
- R11: The effective address wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Block can accept an instruction |
| in_claim | output | 1 | Word decodes as a prefetch |
| in_insn | input | 32 | Instruction word |
| in_base | input | 32 | Base register value |
| eva_enable | input | 1 | User-mode-translation feature present and enabled |
| cp0_enable | input | 1 | System coprocessor usable |
| xlat_addr | output | 32 | Effective address to translate |
| xlat_user | output | 1 | Translate with user privileges |
| xlat_fault | input | 1 | Translation or addressing fault |
| xlat_uncached | input | 1 | Address is uncached |
| xlat_locked | input | 1 | Target line is locked |
| res_valid | output | 1 | Outcome pulse |
| res_kind | output | 2 | 1 issued, 2 dropped, 3 exception |
| res_exc | output | 2 | 0 none, 1 reserved instruction, 2 coprocessor unusable |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Cache side takes the request |
| req_addr | output | 32 | Request address |
| req_level | output | 2 | Target cache level |
| req_store | output | 1 | Store intent |
| req_class | output | 2 | Usage class |
| req_user | output | 1 | Request was user-mode translated |

## Verification
Several properties are checked on every cycle: the single outcome pulse after each acceptance, the hold of a stalled request, the closed input while a request is pending, the refusal of hint 31, the agreement of the exception code with the outcome kind, and the tie between an issued outcome and a live request. Only the bench scenarios can show the rest. These are the level and class mapping for each hint, signed and unsigned address arithmetic including wraparound, the priority of the two exceptions over each other and over the no-op rules, and the silent drop for faults, uncached addresses and locked lines.

// File: rtl/prefetch_issue.sv
module prefetch_issue #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          in_claim,
  input  logic [31:0]   in_insn,
  input  logic [AW-1:0] in_base,
  input  logic          eva_enable,
  input  logic          cp0_enable,
  output logic [AW-1:0] xlat_addr,
  output logic          xlat_user,
  input  logic          xlat_fault,
  input  logic          xlat_uncached,
  input  logic          xlat_locked,
  output logic          res_valid,
  output logic [1:0]    res_kind,
  output logic [1:0]    res_exc,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_level,
  output logic          req_store,
  output logic [1:0]    req_class,
  output logic          req_user
);
  localparam logic [1:0] K_ISSUE = 2'd1, K_DROP = 2'd2, K_EXC = 2'd3;
  localparam logic [1:0] E_RI = 2'd1, E_CPU = 2'd2;

  logic [4:0] hint;
  logic is_s, is_u, is_eva, accept, ri, cpu, nop, drop;
  logic [AW-1:0] disp;
  logic [1:0] cls;
  logic unused_rs;

  assign hint      = in_insn[25:21];
  assign unused_rs = ^in_insn[20:16];
  assign is_s = (in_insn[31:26] == 6'b101001) && (in_insn[14:10] == 5'b00110) && !in_insn[8];
  assign is_u = (in_insn[31:26] == 6'b100001) && (in_insn[15:12] == 4'b0011);
  assign in_claim = (is_s || is_u) && (hint != 5'd31);
  assign is_eva   = is_s && in_insn[9];

  assign disp = is_s ? {{(AW-8){in_insn[15]}}, in_insn[7:0]}
                     : {{(AW-12){1'b0}}, in_insn[11:0]};
  assign xlat_addr = in_base + disp;
  assign xlat_user = in_claim && is_eva;

  assign in_ready = !req_valid;
  assign accept   = in_valid && in_ready && in_claim;

  assign ri   = is_eva && !eva_enable;
  assign cpu  = is_eva && eva_enable && !cp0_enable;
  assign nop  = (hint[4:3] == 2'b11) || (hint[2:0] == 3'd3);
  assign drop = nop || xlat_fault || xlat_uncached || xlat_locked;

  always_comb begin
    unique case (hint[2:0])
      3'd2:       cls = 2'd3;
      3'd4, 3'd5: cls = 2'd1;
      3'd6, 3'd7: cls = 2'd2;
      default:    cls = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= 2'd0;
      res_exc   <= 2'd0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_level <= 2'd0;
      req_store <= 1'b0;
      req_class <= 2'd0;
      req_user  <= 1'b0;
    end else begin
      res_valid <= accept;
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (accept) begin
        res_exc <= 2'd0;
        if (ri) begin
          res_kind <= K_EXC;
          res_exc  <= E_RI;
        end else if (cpu) begin
          res_kind <= K_EXC;
          res_exc  <= E_CPU;
        end else if (drop) begin
          res_kind <= K_DROP;
        end else begin
          res_kind  <= K_ISSUE;
          req_valid <= 1'b1;
          req_addr  <= xlat_addr;
          req_level <= hint[4:3];
          req_store <= hint[0];
          req_class <= cls;
          req_user  <= is_eva;
        end
      end
    end
  end
endmodule

// File: rtl/prefetch_issue_chk.sv
module prefetch_issue_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_claim,
  input logic [31:0]   in_insn,
  input logic          xlat_user,
  input logic          res_valid,
  input logic [1:0]    res_kind,
  input logic [1:0]    res_exc,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_level,
  input logic          req_store,
  input logic [1:0]    req_class,
  input logic          req_user
);
  a_r9_outcome_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_claim) |=> res_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_claim) |=> !res_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_level)
      && $stable(req_store) && $stable(req_class) && $stable(req_user)));
  a_r10_closed: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready);
  a_r3_hint31: assert property (@(posedge clk) disable iff (!rst_n)
    (in_insn[25:21] == 5'd31) |-> !in_claim);
  a_r6_exc_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_kind == 2'd3) == (res_exc != 2'd0)));
  a_r5_issue_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_kind == 2'd1) == req_valid));
  a_r8_user_form: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_user |-> (in_claim && in_insn[31:26] == 6'b101001 && in_insn[9]));
endmodule

bind prefetch_issue prefetch_issue_chk #(.AW(AW)) u_chk (.*);

// File: tb/prefetch_issue_tb.sv
`timescale 1ns/1ps
module prefetch_issue_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_claim;
  logic [31:0] in_insn = '0, in_base = '0;
  logic eva_enable = 1'b0, cp0_enable = 1'b0;
  logic [31:0] xlat_addr;
  logic xlat_user;
  logic xlat_fault = 1'b0, xlat_uncached = 1'b0, xlat_locked = 1'b0;
  logic res_valid;
  logic [1:0] res_kind, res_exc;
  logic req_valid, req_ready = 1'b1;
  logic [31:0] req_addr;
  logic [1:0] req_level, req_class;
  logic req_store, req_user;

  int checks = 0, errors = 0;

  typedef struct { logic [1:0] kind; logic [1:0] exc; string tag; } out_t;
  typedef struct { logic [31:0] addr; logic [1:0] lvl; logic st; logic [1:0] cls; logic usr; string tag; } rq_t;
  out_t out_q[$];
  rq_t  rq_q[$];

  always #2.5 clk = ~clk;

  prefetch_issue u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_s(input logic [4:0] h, input logic [8:0] off, input logic eva);
    return {6'b101001, h, 5'd3, off[8], 4'b0011, 1'b0, eva, 1'b0, off[7:0]};
  endfunction
  function automatic logic [31:0] enc_u(input logic [4:0] h, input logic [11:0] off);
    return {6'b100001, h, 5'd4, 4'b0011, off};
  endfunction

  task automatic send(input logic [31:0] w, input logic [31:0] base, input logic ev, input logic cp,
                      input logic flt, input logic unc, input logic lck, input logic [1:0] ek,
                      input logic [1:0] ee, input logic [31:0] ea, input logic eu, input string tag);
    out_t o;
    rq_t r;
    logic [4:0] h;
    h = w[25:21];
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_insn = w; in_base = base; eva_enable = ev; cp0_enable = cp;
    xlat_fault = flt; xlat_uncached = unc; xlat_locked = lck; in_valid = 1'b1;
    #0.5;
    chk(in_claim === 1'b1, {tag, " claim"}, {31'd0, in_claim}, 32'd1);
    chk(xlat_addr === ea, {tag, " xlat_addr"}, xlat_addr, ea);
    chk(xlat_user === eu, {tag, " R8 xlat_user"}, {31'd0, xlat_user}, {31'd0, eu});
    o.kind = ek; o.exc = ee; o.tag = tag;
    out_q.push_back(o);
    if (ek == 2'd1) begin
      r.addr = ea; r.lvl = h[4:3]; r.st = h[0]; r.usr = eu; r.tag = tag;
      case (h[2:0])
        3'd2: r.cls = 2'd3;
        3'd4, 3'd5: r.cls = 2'd1;
        3'd6, 3'd7: r.cls = 2'd2;
        default: r.cls = 2'd0;
      endcase
      rq_q.push_back(r);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; xlat_fault = 1'b0; xlat_uncached = 1'b0; xlat_locked = 1'b0;
  endtask

  task automatic reject(input logic [31:0] w, input string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_insn = w; in_valid = 1'b1;
    #0.5;
    chk(in_claim === 1'b0, {tag, " R3 not claimed"}, {31'd0, in_claim}, 32'd0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  logic stalled = 1'b0;
  logic [31:0] s_addr;
  logic [1:0] s_lvl, s_cls;
  logic s_st, s_usr;

  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (res_valid) begin
          if (out_q.size() == 0) chk(1'b0, "R9 unexpected outcome", {30'd0, res_kind}, 32'd0);
          else begin
            out_t o;
            o = out_q.pop_front();
            chk(res_kind === o.kind, {o.tag, " R9 kind"}, {30'd0, res_kind}, {30'd0, o.kind});
            chk(res_exc === o.exc, {o.tag, " R6 exc"}, {30'd0, res_exc}, {30'd0, o.exc});
          end
        end
        if (req_valid) begin
          chk(in_ready === 1'b0, "R10 input closed while pending", {31'd0, in_ready}, 32'd0);
          if (stalled)
            chk(req_addr === s_addr && req_lvl_ok(s_lvl) && req_class === s_cls
                && req_store === s_st && req_user === s_usr,
                "R10 request held", req_addr, s_addr);
          if (req_ready) begin
            if (rq_q.size() == 0) chk(1'b0, "R9 unexpected request", req_addr, 32'd0);
            else begin
              rq_t r;
              r = rq_q.pop_front();
              chk(req_addr === r.addr, {r.tag, " req_addr"}, req_addr, r.addr);
              chk(req_level === r.lvl, {r.tag, " R4 level"}, {30'd0, req_level}, {30'd0, r.lvl});
              chk(req_store === r.st && req_class === r.cls, {r.tag, " R4 store/class"},
                  {29'd0, req_store, req_class}, {29'd0, r.st, r.cls});
              chk(req_user === r.usr, {r.tag, " R8 req_user"}, {31'd0, req_user}, {31'd0, r.usr});
            end
          end
        end
        stalled = req_valid && !req_ready;
        s_addr = req_addr; s_lvl = req_level; s_cls = req_class; s_st = req_store; s_usr = req_user;
      end
    end
  end

  function automatic bit req_lvl_ok(input logic [1:0] v);
    return req_level === v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(res_valid === 1'b0 && req_valid === 1'b0, "R9 reset idle", {30'd0, res_valid, req_valid}, 32'd0);
    chk(in_ready === 1'b1, "R10 reset ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    send(enc_s(5'd0, 9'd5, 1'b0), 32'h1000, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h1005, 0, "R1 pos disp load L1");
    send(enc_s(5'd9, 9'h100, 1'b0), 32'h1000, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h0F00, 0, "R1 neg disp store L2");
    send(enc_u(5'd20, 12'hFFF), 32'h10, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h100F, 0, "R2 unsigned L3 streamed");
    send(enc_u(5'd6, 12'h020), 32'hFFFF_FFF0, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h10, 0, "R11 wrap up");
    send(enc_s(5'd7, 9'h1FF, 1'b0), 32'h0, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'hFFFF_FFFF, 0, "R11 wrap down");
    send(enc_s(5'd2, 9'd0, 1'b0), 32'h2000, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h2000, 0, "R4 lru mark");
    send(enc_u(5'd13, 12'h0), 32'h40, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h40, 0, "R4 L2 store streamed");
    send(enc_s(5'd23, 9'd8, 1'b0), 32'h40, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h48, 0, "R4 L3 store retained");

    send(enc_s(5'd3, 9'd0, 1'b0), 32'h80, 0, 1, 0, 0, 0, 2'd2, 2'd0, 32'h80, 0, "R5 hint 3");
    send(enc_u(5'd24, 12'h1), 32'h80, 0, 1, 0, 0, 0, 2'd2, 2'd0, 32'h81, 0, "R5 hint 24");
    send(enc_s(5'd30, 9'd1, 1'b0), 32'h80, 0, 1, 0, 0, 0, 2'd2, 2'd0, 32'h81, 0, "R5 hint 30");

    reject(enc_s(5'd31, 9'd0, 1'b0), "R3 hint31 signed");
    reject(enc_u(5'd31, 12'd0), "R3 hint31 unsigned");
    reject(32'h0000_0000, "R3 other word");
    reject(enc_s(5'd0, 9'd0, 1'b0) | 32'h0000_0100, "R3 bad bits 9:8");

    send(enc_s(5'd0, 9'd4, 1'b1), 32'h100, 0, 0, 0, 0, 0, 2'd3, 2'd1, 32'h104, 1, "R6 ri over cpu");
    send(enc_s(5'd0, 9'd4, 1'b1), 32'h100, 0, 1, 0, 0, 0, 2'd3, 2'd1, 32'h104, 1, "R6 ri");
    send(enc_s(5'd0, 9'd4, 1'b1), 32'h100, 1, 0, 0, 0, 0, 2'd3, 2'd2, 32'h104, 1, "R6 cpu");
    send(enc_s(5'd25, 9'd4, 1'b1), 32'h100, 0, 1, 1, 0, 0, 2'd3, 2'd1, 32'h104, 1, "R6 exc over nop");
    send(enc_s(5'd6, 9'd4, 1'b1), 32'h100, 1, 1, 0, 0, 0, 2'd1, 2'd0, 32'h104, 1, "R8 user issue");

    send(enc_u(5'd0, 12'h8), 32'h300, 0, 1, 1, 0, 0, 2'd2, 2'd0, 32'h308, 0, "R7 fault");
    send(enc_u(5'd1, 12'h8), 32'h300, 0, 1, 0, 1, 0, 2'd2, 2'd0, 32'h308, 0, "R7 uncached");
    send(enc_u(5'd4, 12'h8), 32'h300, 0, 1, 0, 0, 1, 2'd2, 2'd0, 32'h308, 0, "R7 locked");

    @(negedge clk); req_ready = 1'b0;
    send(enc_u(5'd15, 12'h44), 32'h5000, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h5044, 0, "R10 stalled");
    repeat (6) @(negedge clk);
    req_ready = 1'b1;
    send(enc_s(5'd1, 9'd0, 1'b0), 32'h6000, 0, 1, 0, 0, 0, 2'd1, 2'd0, 32'h6000, 0, "R10 after stall");

    repeat (6) @(posedge clk);
    #1;
    chk(out_q.size() == 0, "R9 all outcomes seen", out_q.size(), 32'd0);
    chk(rq_q.size() == 0, "R10 all requests seen", rq_q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule